// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Engine

This block is the register file and transfer bookkeeping for one bus-mastering DMA channel that sits beside a SCSI protocol core. Software programs a start byte count, a start memory address and a start descriptor-list address, then writes a command word. A start command copies the three start values into their working copies, clears the status flags and enables the core's DMA path. An idle command turns that path off, and an abort command sends a one-cycle cancel pulse to the core. A blast command is accepted and stored but changes nothing else.

As the core moves data it presents one chunk request at a time, with a length and a direction. The engine checks the direction against the command word and rejects a mismatch. It clips an accepted length to the remaining working count, returns the memory address and the clipped length, and then advances the working address and shrinks the working count. When the count reaches zero, or when the core reports that its command has completed, the done flag rises. A control register selects how software clears the error, abort and done flags: they clear either when status is read or when a one is written over them.

Top module: `bmdma_chan`

## Requirements
- R1: After reset, the command reads 0, the working count reads 0, the working address reads 0xFFFFFFFF, the working list address reads 0xFFFFFFFD, status reads 0 (with core_irq low), and core_dma_en, core_abort and xfer_done are low.
- R2: The start count (offset 1), start address (offset 2), start list address (offset 6) and control register (offset 8) are written and read back in full. Read data appears on reg_rdata in the cycle after the reg_rd cycle.
- R3: Writes are ignored in these cases, and the bench reads the register afterwards to confirm: the working count (3), the working address (4), the working list address (7), offsets 9 to 15, and status (5) when control bit 24 is 0. Reads of offsets 9 to 15 return 0.
- R4: Command bits [1:0] = 3 (start) copies offset 1 to 3, offset 2 to 4 and offset 6 to 7. It also clears status bits [5:0] and sets core_dma_en.
- R5: Command code 0 (idle) clears core_dma_en. Code 1 (blast) leaves core_dma_en and the working registers unchanged. Code 2 (abort) raises core_abort for exactly one cycle. The command register reads back the last value written.
- R6: A chunk whose chunk_dir differs from command bit 7 (1 = device to memory) is acknowledged with chunk_ok = 0 and dma_len = 0, and it leaves the working count and working address unchanged.
- R7: An accepted chunk returns dma_addr equal to the working address before the chunk and dma_len equal to the minimum of chunk_len and the working count. The working count then decreases by dma_len and the working address increases by dma_len.
- R8: When an accepted chunk brings the working count to zero, status bit 3 (done) sets and xfer_done goes high.
- R9: A status read returns bit 4 set whenever core_irq is high during the read cycle.
- R10: With control bit 24 at 0, a status read returns status bits 1 to 3 and then clears them.
- R11: With control bit 24 at 1, status reads do not clear any bit. A status write clears each of bits 1 to 3 where the matching write-data bit is 1.
- R12: A core_done pulse forces the working count to 0 and sets the done flag.
- R13: chunk_ack is a one-cycle pulse in the cycle after chunk_req is sampled. A request that is still held while chunk_ack is high is not taken a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| core_irq | input | 1 | Interrupt flag from the SCSI core |
| core_done | input | 1 | Command-complete pulse from the core |
| chunk_req | input | 1 | Chunk transfer request |
| chunk_len | input | LEN_W | Requested chunk length in bytes |
| chunk_dir | input | 1 | Chunk direction, 1 = device to memory |
| chunk_ack | output | 1 | One-cycle acknowledge |
| chunk_ok | output | 1 | Chunk accepted (valid with chunk_ack) |
| dma_addr | output | DATA_W | Memory address for the chunk |
| dma_len | output | LEN_W | Clipped chunk length |
| core_dma_en | output | 1 | DMA enable to the core |
| core_abort | output | 1 | Cancel pulse to the core |
| xfer_done | output | 1 | Done flag (status bit 3) |

## Verification
A wrong working count or working address shows up at the next chunk acknowledge, as a dma_addr or dma_len that differs from the running sum the bench keeps. It also shows up at the next read of offsets 3 or 4, one cycle after the read strobe. A status flag that fails to clear, or clears too early, shows up in the first status read after the clearing event, so each clearing mode is checked with two back-to-back status reads. A mis-decoded command shows up one cycle after the command write, on core_dma_en or core_abort.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

   // register word offsets
   localparam int unsigned OFS_CMD  = 0;
   localparam int unsigned OFS_SCNT = 1;
   localparam int unsigned OFS_SADR = 2;
   localparam int unsigned OFS_WCNT = 3;
   localparam int unsigned OFS_WADR = 4;
   localparam int unsigned OFS_STAT = 5;
   localparam int unsigned OFS_SLST = 6;
   localparam int unsigned OFS_WLST = 7;
   localparam int unsigned OFS_CTL  = 8;

   // command word fields
   localparam int unsigned CMD_DIR_B = 7;

   // control word: selects write-one-to-clear status
   localparam int unsigned CTL_W1C_B = 24;

   // status flags
   localparam int unsigned ST_W    = 6;
   localparam int unsigned ST_DONE = 3;
   localparam int unsigned ST_IRQ  = 4;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_BLAST = 2'd1,
      OP_ABORT = 2'd2,
      OP_START = 2'd3
   } dma_op_e;

endpackage

// File: rtl/bmdma_cmd_dec.sv
module bmdma_cmd_dec
   import bmdma_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic [DATA_W-1:0] cmd_q,
   output logic              start_p,
   output logic              dma_en,
   output logic              abort_q
);

   dma_op_e op;

   assign op      = dma_op_e'(cmd_wdata[1:0]);
   assign start_p = cmd_wr && (op == OP_START);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         dma_en  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         abort_q <= 1'b0;
         if (cmd_wr) begin
            cmd_q <= cmd_wdata;
            unique case (op)
               OP_IDLE:  dma_en  <= 1'b0;
               OP_BLAST: ;
               OP_ABORT: abort_q <= 1'b1;
               OP_START: dma_en  <= 1'b1;
               default:  ;
            endcase
         end
      end
   end

   // R5: a cancel pulse only follows an abort command write
   p_abort_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> $past(cmd_wr && cmd_wdata[1:0] == 2'd2));

endmodule

// File: rtl/bmdma_xfer.sv
module bmdma_xfer #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_cnt,
   input  logic [DATA_W-1:0] ld_adr,
   input  logic [DATA_W-1:0] ld_lst,
   input  logic              cmd_dir,
   input  logic              core_done,
   input  logic              req,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_dir,
   output logic [DATA_W-1:0] wcnt,
   output logic [DATA_W-1:0] wadr,
   output logic [DATA_W-1:0] wlst,
   output logic              ack_q,
   output logic              ok_q,
   output logic [DATA_W-1:0] addr_q,
   output logic [LEN_W-1:0]  len_q,
   output logic              zero_ev
);

   localparam logic [DATA_W-1:0] CNT_RST = '0;
   localparam logic [DATA_W-1:0] ADR_RST = '1;
   localparam logic [DATA_W-1:0] LST_RST = ~DATA_W'(2);

   logic [DATA_W-1:0] len_x;
   logic [DATA_W-1:0] clip;
   logic              take;
   logic              accept;

   if (LEN_W > DATA_W) begin : g_bad_len
      $error("bmdma_xfer: LEN_W must not exceed DATA_W");
   end

   if (LEN_W == DATA_W) begin : g_len_full
      assign len_x = req_len;
   end else begin : g_len_ext
      assign len_x = {{(DATA_W-LEN_W){1'b0}}, req_len};
   end

   assign take    = req && !ack_q;
   assign accept  = take && (req_dir == cmd_dir);
   assign clip    = (len_x < wcnt) ? len_x : wcnt;
   assign zero_ev = accept && !load && !core_done && (clip == wcnt);

   for (genvar i = 0; i < 3; i++) begin : g_work
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] nxt;
      logic [DATA_W-1:0] rv;
      if (i == 0) begin : g_cnt
         assign rv = CNT_RST;
         always_comb begin
            if (core_done)   nxt = '0;
            else if (load)   nxt = ld_cnt;
            else if (accept) nxt = q - clip;
            else             nxt = q;
         end
         assign wcnt = q;
      end else if (i == 1) begin : g_adr
         assign rv = ADR_RST;
         always_comb begin
            if (load)        nxt = ld_adr;
            else if (accept) nxt = q + clip;
            else             nxt = q;
         end
         assign wadr = q;
      end else begin : g_lst
         assign rv = LST_RST;
         always_comb begin
            if (load) nxt = ld_lst;
            else      nxt = q;
         end
         assign wlst = q;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) q <= rv;
         else        q <= nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         ok_q   <= 1'b0;
         addr_q <= '0;
         len_q  <= '0;
      end else begin
         ack_q <= take;
         ok_q  <= accept;
         if (take) begin
            addr_q <= wadr;
            len_q  <= accept ? clip[LEN_W-1:0] : '0;
         end
      end
   end

   // R13: acknowledge never lasts two cycles
   p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);

   // R7: granted length never exceeds the count it was clipped to
   p_len_clip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q && ok_q) |-> ($past(wcnt) >= DATA_W'(len_q)));

   // R6: a rejected chunk leaves the count alone
   p_drop_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q && !ok_q && $past(!load && !core_done)) |-> (wcnt == $past(wcnt)));

endmodule

// File: rtl/bmdma_stat.sv
module bmdma_stat
   import bmdma_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_start,
   input  logic              set_done,
   input  logic              rd_stat,
   input  logic              wr_stat,
   input  logic [2:0]        wclr,
   input  logic              w1c_mode,
   input  logic              core_irq,
   output logic [DATA_W-1:0] view,
   output logic              done
);

   logic [ST_W-1:0] st_q;
   logic [ST_W-1:0] st_n;

   always_comb begin
      st_n = st_q;
      if (rd_stat && !w1c_mode) st_n[3:1] = 3'b000;
      if (wr_stat && w1c_mode)  st_n[3:1] = st_q[3:1] & ~wclr;
      if (clr_start)            st_n = '0;
      if (set_done)             st_n[ST_DONE] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_n;
   end

   always_comb begin
      view = '0;
      view[ST_W-1:0] = st_q;
      view[ST_IRQ] = st_q[ST_IRQ] | core_irq;
   end

   assign done = st_q[ST_DONE];

   // R8 / R12: a done event is visible on the next cycle
   p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |=> st_q[ST_DONE]);

   // R10: clear-on-read mode empties error, abort and done
   p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !w1c_mode && !set_done && !clr_start) |=> (st_q[3:1] == 3'b000));

   // R11: write-one-to-clear mode keeps flags across a plain read
   p_rd_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && w1c_mode && !wr_stat && !clr_start) |=> (st_q[3:1] >= $past(st_q[3:1])));

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
   import bmdma_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned AW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              core_irq,
   input  logic              core_done,
   input  logic              chunk_req,
   input  logic [LEN_W-1:0]  chunk_len,
   input  logic              chunk_dir,
   output logic              chunk_ack,
   output logic              chunk_ok,
   output logic [DATA_W-1:0] dma_addr,
   output logic [LEN_W-1:0]  dma_len,
   output logic              core_dma_en,
   output logic              core_abort,
   output logic              xfer_done
);

   if (DATA_W < CTL_W1C_B + 1) begin : g_bad_data
      $error("bmdma_chan: DATA_W too narrow for the control word");
   end
   if (AW < 4) begin : g_bad_aw
      $error("bmdma_chan: AW must reach offset 8");
   end

   logic [DATA_W-1:0] scnt_q, sadr_q, slst_q, ctl_q;
   logic [DATA_W-1:0] cmd_q;
   logic [DATA_W-1:0] wcnt, wadr, wlst;
   logic [DATA_W-1:0] st_view;
   logic [DATA_W-1:0] rd_mux;
   logic              start_p;
   logic              zero_ev;
   logic              wr_cmd, wr_stat, rd_stat;

   assign wr_cmd  = reg_wr && (reg_addr == AW'(OFS_CMD));
   assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
   assign rd_stat = reg_rd && (reg_addr == AW'(OFS_STAT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scnt_q <= '0;
         sadr_q <= '0;
         slst_q <= '0;
         ctl_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == AW'(OFS_SCNT)) scnt_q <= reg_wdata;
         if (reg_addr == AW'(OFS_SADR)) sadr_q <= reg_wdata;
         if (reg_addr == AW'(OFS_SLST)) slst_q <= reg_wdata;
         if (reg_addr == AW'(OFS_CTL))  ctl_q  <= reg_wdata;
      end
   end

   bmdma_cmd_dec #(.DATA_W(DATA_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (wr_cmd),
      .cmd_wdata (reg_wdata),
      .cmd_q     (cmd_q),
      .start_p   (start_p),
      .dma_en    (core_dma_en),
      .abort_q   (core_abort)
   );

   bmdma_xfer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_p),
      .ld_cnt    (scnt_q),
      .ld_adr    (sadr_q),
      .ld_lst    (slst_q),
      .cmd_dir   (cmd_q[CMD_DIR_B]),
      .core_done (core_done),
      .req       (chunk_req),
      .req_len   (chunk_len),
      .req_dir   (chunk_dir),
      .wcnt      (wcnt),
      .wadr      (wadr),
      .wlst      (wlst),
      .ack_q     (chunk_ack),
      .ok_q      (chunk_ok),
      .addr_q    (dma_addr),
      .len_q     (dma_len),
      .zero_ev   (zero_ev)
   );

   bmdma_stat #(.DATA_W(DATA_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_start (start_p),
      .set_done  (zero_ev | core_done),
      .rd_stat   (rd_stat),
      .wr_stat   (wr_stat),
      .wclr      (reg_wdata[3:1]),
      .w1c_mode  (ctl_q[CTL_W1C_B]),
      .core_irq  (core_irq),
      .view      (st_view),
      .done      (xfer_done)
   );

   always_comb begin
      unique case (reg_addr)
         AW'(OFS_CMD):  rd_mux = cmd_q;
         AW'(OFS_SCNT): rd_mux = scnt_q;
         AW'(OFS_SADR): rd_mux = sadr_q;
         AW'(OFS_WCNT): rd_mux = wcnt;
         AW'(OFS_WADR): rd_mux = wadr;
         AW'(OFS_STAT): rd_mux = st_view;
         AW'(OFS_SLST): rd_mux = slst_q;
         AW'(OFS_WLST): rd_mux = wlst;
         AW'(OFS_CTL):  rd_mux = ctl_q;
         default:       rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   // R4: a start command turns the core path on
   p_start_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> core_dma_en);

endmodule

// File: tb/bmdma_chan_test.sv
`timescale 1ns/1ps
module bmdma_chan_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        core_irq = 1'b0, core_done = 1'b0;
   logic        chunk_req = 1'b0, chunk_dir = 1'b0;
   logic [15:0] chunk_len = '0;
   logic        chunk_ack, chunk_ok;
   logic [31:0] dma_addr;
   logic [15:0] dma_len;
   logic        core_dma_en, core_abort, xfer_done;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   bmdma_chan uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .core_irq(core_irq), .core_done(core_done), .chunk_req(chunk_req),
      .chunk_len(chunk_len), .chunk_dir(chunk_dir), .chunk_ack(chunk_ack),
      .chunk_ok(chunk_ok), .dma_addr(dma_addr), .dma_len(dma_len),
      .core_dma_en(core_dma_en), .core_abort(core_abort), .xfer_done(xfer_done)
   );

   typedef struct { logic [31:0] exp; string tag; } rexp_t;
   typedef struct { logic ok; logic [31:0] addr; logic [15:0] len; string tag; } cexp_t;
   rexp_t rq[$];
   cexp_t cq[$];

   logic rd_q = 1'b0;
   always @(posedge clk) rd_q <= reg_rd;

   // read monitor
   always @(negedge clk) begin
      rexp_t e;
      if (rd_q) begin
         total++;
         if (rq.size() == 0) begin
            bad++;
            $display("FAIL read without expectation act=%h", reg_rdata);
         end else begin
            e = rq.pop_front();
            if (reg_rdata !== e.exp) begin
               bad++;
               $display("FAIL %s read act=%h exp=%h", e.tag, reg_rdata, e.exp);
            end
         end
      end
   end

   // chunk monitor
   always @(negedge clk) begin
      cexp_t c;
      if (chunk_ack === 1'b1) begin
         total++;
         if (cq.size() == 0) begin
            bad++;
            $display("FAIL R13 unexpected ack act=1 exp=0");
         end else begin
            c = cq.pop_front();
            if (chunk_ok !== c.ok || dma_addr !== c.addr || dma_len !== c.len) begin
               bad++;
               $display("FAIL %s chunk act=%b/%h/%h exp=%b/%h/%h", c.tag,
                        chunk_ok, dma_addr, dma_len, c.ok, c.addr, c.len);
            end
         end
      end
   end

   task automatic chk(input logic cond, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      rexp_t e;
      e.exp = exp; e.tag = tag;
      @(negedge clk);
      rq.push_back(e);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chunk(input logic [15:0] len, input logic dir, input logic ok,
                        input logic [31:0] addr, input logic [15:0] elen, input string tag);
      cexp_t c;
      c.ok = ok; c.addr = addr; c.len = elen; c.tag = tag;
      @(negedge clk);
      cq.push_back(c);
      chunk_req = 1'b1; chunk_len = len; chunk_dir = dir;
      @(negedge clk);
      chunk_req = 1'b0;
      @(negedge clk);
      chk(chunk_ack == 1'b0, "R13 ack width", {31'd0, chunk_ack}, 32'd0);
   endtask

   task automatic finish_up();
      total++;
      if (rq.size() != 0 || cq.size() != 0) begin
         bad++;
         $display("FAIL R13 pending items act=%0d exp=0", rq.size() + cq.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(core_dma_en == 1'b0 && core_abort == 1'b0 && xfer_done == 1'b0, "R1 outputs",
          {29'd0, core_dma_en, core_abort, xfer_done}, 32'd0);
      rd(4'd0, 32'h0, "R1 cmd");
      rd(4'd3, 32'h0, "R1 wcnt");
      rd(4'd4, 32'hFFFF_FFFF, "R1 wadr");
      rd(4'd7, 32'hFFFF_FFFD, "R1 wlst");
      rd(4'd5, 32'h0, "R1 status");
      // R2 programmable registers
      wr(4'd1, 32'h0000_0010);
      wr(4'd2, 32'h0000_1000);
      wr(4'd6, 32'h0000_ABC0);
      wr(4'd8, 32'h0000_0000);
      rd(4'd1, 32'h0000_0010, "R2 scnt");
      rd(4'd2, 32'h0000_1000, "R2 sadr");
      rd(4'd6, 32'h0000_ABC0, "R2 slst");
      rd(4'd8, 32'h0, "R2 ctl");
      // R3 ignored writes
      wr(4'd3, 32'h55); wr(4'd4, 32'h66); wr(4'd7, 32'h77); wr(4'd12, 32'h99);
      rd(4'd3, 32'h0, "R3 wcnt");
      rd(4'd4, 32'hFFFF_FFFF, "R3 wadr");
      rd(4'd7, 32'hFFFF_FFFD, "R3 wlst");
      rd(4'd12, 32'h0, "R3 hole");
      // R4 start, direction memory-to-device
      wr(4'd0, 32'h03);
      chk(core_dma_en == 1'b1, "R4 dma_en", {31'd0, core_dma_en}, 32'd1);
      rd(4'd3, 32'h10, "R4 wcnt");
      rd(4'd4, 32'h1000, "R4 wadr");
      rd(4'd7, 32'hABC0, "R4 wlst");
      // R6 wrong direction
      chunk(16'd4, 1'b1, 1'b0, 32'h1000, 16'd0, "R6 reject");
      rd(4'd3, 32'h10, "R6 wcnt kept");
      // R7 / R8 accepted and clipped
      chunk(16'd6, 1'b0, 1'b1, 32'h1000, 16'd6, "R7 first");
      chk(xfer_done == 1'b0, "R8 not yet", {31'd0, xfer_done}, 32'd0);
      chunk(16'h20, 1'b0, 1'b1, 32'h1006, 16'hA, "R7 clip");
      chk(xfer_done == 1'b1, "R8 done", {31'd0, xfer_done}, 32'd1);
      rd(4'd3, 32'h0, "R7 wcnt");
      rd(4'd4, 32'h1010, "R7 wadr");
      // R9 / R10 clear on read
      core_irq = 1'b1;
      rd(4'd5, 32'h18, "R9 irq live");
      core_irq = 1'b0;
      rd(4'd5, 32'h0, "R10 cleared");
      // R12 core completion, status write ignored in this mode
      wr(4'd1, 32'h8);
      wr(4'd0, 32'h03);
      rd(4'd3, 32'h8, "R12 wcnt before");
      @(negedge clk); core_done = 1'b1;
      @(negedge clk); core_done = 1'b0;
      wr(4'd5, 32'hFF);
      rd(4'd3, 32'h0, "R12 wcnt zero");
      rd(4'd5, 32'h08, "R12 done / R3 stat write ignored");
      rd(4'd5, 32'h0, "R10 second read");
      // R11 write-one-to-clear, device-to-memory direction
      wr(4'd8, 32'h0100_0000);
      wr(4'd0, 32'h83);
      chunk(16'd8, 1'b1, 1'b1, 32'h1000, 16'd8, "R7 dir1");
      rd(4'd5, 32'h08, "R11 read one");
      rd(4'd5, 32'h08, "R11 read keeps");
      wr(4'd5, 32'h04);
      rd(4'd5, 32'h08, "R11 other bit");
      wr(4'd5, 32'h08);
      rd(4'd5, 32'h0, "R11 cleared");
      // R5 command codes
      wr(4'd0, 32'h00);
      chk(core_dma_en == 1'b0, "R5 idle", {31'd0, core_dma_en}, 32'd0);
      wr(4'd0, 32'h03);
      wr(4'd0, 32'h01);
      chk(core_dma_en == 1'b1, "R5 blast keeps en", {31'd0, core_dma_en}, 32'd1);
      rd(4'd3, 32'h8, "R5 blast keeps wcnt");
      wr(4'd0, 32'h02);
      chk(core_abort == 1'b1, "R5 abort pulse", {31'd0, core_abort}, 32'd1);
      @(negedge clk);
      chk(core_abort == 1'b0, "R5 abort one cycle", {31'd0, core_abort}, 32'd0);
      rd(4'd0, 32'h02, "R5 cmd readback");
      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule